// File: doc/BRIEF.md
# Write-Through Store Buffer with Read Bypass

This block sits between a write-through cache and the next memory level. Processor stores are parked in a small queue, so the processor does not wait for memory on each store. The queue sends its entries to memory one at a time, oldest first. Because it holds several entries, a burst of back-to-back stores fits in it without a stall.

A read that missed the cache is compared against every parked store. If any stored address matches, the data of the youngest matching store goes straight back to the processor and memory is not touched. If nothing matches, the read goes to memory ahead of the older stores still queued. The only exception is a store already presented to memory: that store finishes first. While a read waits for its memory data, no more stores are sent to memory. This keeps the memory-side order simple.

Top module: `wtbuf_bypass`

## Requirements
- R1: After reset, `wr_ready` and `rd_ready` are 1, and `mem_req_valid` and `rd_resp_valid` are 0.
- R2: A store offered while the queue has a free entry is taken on that edge, even when memory accepts nothing.
- R3: The queue holds DEPTH (default 4) stores. While it is full, `wr_ready` is 0. It returns to 1 once an entry has been sent, and the stalled store is then taken without loss.
- R4: Stores go to memory in the order they were taken. Each one is a request with `mem_req_write` = 1 carrying that store's address and data, and one entry leaves per accepted request.
- R5: A store request presented with `mem_req_ready` = 0 stays presented, with the same address and data, until memory accepts it.
- R6: A read whose word address matches no queued store is sent to memory with `mem_req_write` = 0 before any queued store that was not yet presented. Its response carries the memory data.
- R7: A read whose word address matches a queued store returns, in the cycle after it is taken, the data of the youngest matching store. No read request goes to memory for it.
- R8: A store request already presented when a read arrives is completed before that read is sent to memory.
- R9: From the moment a read is accepted by memory until its data returns, `mem_req_valid` is 0 and `rd_ready` is 0.
- R10: Read data from memory appears on `rd_resp_data`, with `rd_resp_valid` = 1 for one cycle, in the cycle after `mem_resp_valid`.
- R11: A store offered into a full queue while a read is pending is not lost. Both complete, in the order: presented store, read, remaining stores, new store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Processor offers a store |
| wr_ready | output | 1 | Queue can take a store |
| wr_addr | input | AW | Store word address |
| wr_data | input | DW | Store data |
| rd_valid | input | 1 | Processor issues a read that missed the cache |
| rd_ready | output | 1 | Read can be taken |
| rd_addr | input | AW | Read word address |
| rd_resp_valid | output | 1 | Read data valid (one cycle) |
| rd_resp_data | output | DW | Read data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = store, 0 = read |
| mem_req_addr | output | AW | Request word address |
| mem_req_data | output | DW | Store data (0 for reads) |
| mem_resp_valid | input | 1 | Memory read data valid |
| mem_resp_data | input | DW | Memory read data |

## Verification
The bench records every memory handshake in order, so a wrong queue pointer or a wrong occupancy count shows up as a wrong store order or wrong store data. It appears at the first drain that follows, and `wr_ready` is also wrong at the fill boundary. A bad match decision has two visible signs: a forwarded read shows the wrong data one cycle after acceptance, or a read request appears at the memory port when none should. If the read state machine or the hold of a presented store is wrong, the memory port sees a request in the wrong order or a request while a read is outstanding. That shows within a cycle or two of the read being taken.

// File: rtl/wbuf_pkg.sv
// Package: shared types for the write-through store buffer.
// Assumes: nothing beyond SystemVerilog enums.
package wbuf_pkg;
    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_PEND = 2'd1,
        RD_WAIT = 2'd2,
        RD_RESP = 2'd3
    } rd_state_e;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_DRAIN = 2'd1,
        SRC_READ  = 2'd2
    } mem_src_e;
endpackage

// File: rtl/wbuf_store.sv
// Module: wbuf_store
// Circular queue of DEPTH store entries with per-slot valid bits, exposed
// in parallel so a comparator can see every slot.
// Assumes: push is never raised when full and pop never when empty.
module wbuf_store #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [AW-1:0]             push_addr,
    input  logic [DW-1:0]             push_data,
    input  logic                      pop,
    output logic [PW-1:0]             head_idx,
    output logic [DEPTH-1:0]          ent_valid,
    output logic [DEPTH-1:0][AW-1:0]  ent_addr,
    output logic [DEPTH-1:0][DW-1:0]  ent_data,
    output logic [CW-1:0]             count,
    output logic                      full,
    output logic                      not_empty
);
    logic [PW-1:0] tail_idx;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] i);
        return (i == PW'(DEPTH - 1)) ? '0 : i + 1'b1;
    endfunction

    // Pointer, valid-bit and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_idx  <= '0;
            tail_idx  <= '0;
            ent_valid <= '0;
            count     <= '0;
        end else begin
            if (pop) begin
                ent_valid[head_idx] <= 1'b0;
                head_idx            <= step(head_idx);
            end
            if (push) begin
                ent_valid[tail_idx] <= 1'b1;
                tail_idx            <= step(tail_idx);
            end
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // Payload write into the tail slot; payload needs no reset.
    always_ff @(posedge clk) begin
        if (push) begin
            ent_addr[tail_idx] <= push_addr;
            ent_data[tail_idx] <= push_data;
        end
    end

    assign full      = (count == CW'(DEPTH));
    assign not_empty = (count != '0);
endmodule

// File: rtl/wbuf_match.sv
// Module: wbuf_match
// Compares a read word address with every valid slot and picks the youngest
// matching slot by walking the slots in age order from the head.
// Assumes: slots from head onward are ordered oldest to youngest.
module wbuf_match #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [AW-1:0]             look_addr,
    input  logic [PW-1:0]             head_idx,
    input  logic [DEPTH-1:0]          ent_valid,
    input  logic [DEPTH-1:0][AW-1:0]  ent_addr,
    input  logic [DEPTH-1:0][DW-1:0]  ent_data,
    output logic                      hit,
    output logic [DW-1:0]             hit_data
);
    logic [DEPTH-1:0] eq;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign eq[g] = ent_valid[g] && (ent_addr[g] == look_addr);
    end

    // Age-ordered scan: a later (younger) match overrides an earlier one.
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            int s;
            s = (int'(head_idx) + k) % DEPTH;
            if (eq[s[PW-1:0]]) begin
                hit      = 1'b1;
                hit_data = ent_data[s[PW-1:0]];
            end
        end
    end
endmodule

// File: rtl/wbuf_arb.sv
// Module: wbuf_arb
// Chooses the source of the memory request: a store already presented is
// held until accepted, then a pending read wins, then the queue head drains.
// Assumes: drain_ok is low while a read is pending or outstanding.
module wbuf_arb #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_pend,
    input  logic          drain_ok,
    input  logic          have_entry,
    input  logic [AW-1:0] head_addr,
    input  logic [DW-1:0] head_data,
    input  logic [AW-1:0] rd_addr,
    input  logic          mem_req_ready,
    output logic          mem_req_valid,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_data,
    output logic          pop,
    output logic          read_issued
);
    import wbuf_pkg::*;

    mem_src_e src;
    logic     drain_hold;

    // Priority pick of the request source for this cycle.
    always_comb begin
        src = SRC_NONE;
        if (drain_hold)                   src = SRC_DRAIN;
        else if (rd_pend)                 src = SRC_READ;
        else if (drain_ok && have_entry)  src = SRC_DRAIN;
    end

    // Remember a presented store that memory has not yet accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) drain_hold <= 1'b0;
        else        drain_hold <= (src == SRC_DRAIN) && !mem_req_ready;
    end

    assign mem_req_valid = (src != SRC_NONE);
    assign mem_req_write = (src == SRC_DRAIN);
    assign mem_req_addr  = (src == SRC_DRAIN) ? head_addr : rd_addr;
    assign mem_req_data  = (src == SRC_DRAIN) ? head_data : '0;
    assign pop           = (src == SRC_DRAIN) && mem_req_ready;
    assign read_issued   = (src == SRC_READ) && mem_req_ready;
endmodule

// File: rtl/wbuf_rdctl.sv
// Module: wbuf_rdctl
// Read-miss sequencer: takes one read at a time, answers it from the queue
// on a match, or parks it for the arbiter and waits for memory data.
// Assumes: memory returns read data no earlier than the cycle after accept.
module wbuf_rdctl #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_valid,
    input  logic [AW-1:0]        rd_addr,
    input  logic                 hit,
    input  logic [DW-1:0]        hit_data,
    input  logic                 read_issued,
    input  logic                 mem_resp_valid,
    input  logic [DW-1:0]        mem_resp_data,
    output logic                 rd_ready,
    output logic                 rd_resp_valid,
    output logic [DW-1:0]        rd_resp_data,
    output wbuf_pkg::rd_state_e  state,
    output logic [AW-1:0]        pend_addr
);
    import wbuf_pkg::*;

    logic accept;
    assign rd_ready      = (state == RD_IDLE);
    assign accept        = rd_valid && rd_ready;
    assign rd_resp_valid = (state == RD_RESP);

    // Read sequencing and response capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= RD_IDLE;
            pend_addr    <= '0;
            rd_resp_data <= '0;
        end else begin
            case (state)
                RD_IDLE: if (accept) begin
                    if (hit) begin
                        state        <= RD_RESP;
                        rd_resp_data <= hit_data;
                    end else begin
                        state     <= RD_PEND;
                        pend_addr <= rd_addr;
                    end
                end
                RD_PEND: if (read_issued) state <= RD_WAIT;
                RD_WAIT: if (mem_resp_valid) begin
                    state        <= RD_RESP;
                    rd_resp_data <= mem_resp_data;
                end
                default: state <= RD_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wtbuf_bypass.sv
// Module: wtbuf_bypass (top)
// Store queue between a write-through cache and memory, with reads that
// bypass queued stores after an address check against every entry.
// Assumes: word addresses; a store taken in the same cycle as a read is
// ordered after that read.
module wtbuf_bypass #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_valid,
    output logic          rd_ready,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_resp_valid,
    output logic [DW-1:0] rd_resp_data,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_data,
    input  logic          mem_resp_valid,
    input  logic [DW-1:0] mem_resp_data
);
    import wbuf_pkg::*;

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic                     push, pop, full, not_empty;
    logic [PW-1:0]            head_idx;
    logic [DEPTH-1:0]         ent_valid;
    logic [DEPTH-1:0][AW-1:0] ent_addr;
    logic [DEPTH-1:0][DW-1:0] ent_data;
    logic [CW-1:0]            buf_count;
    logic                     fwd_hit;
    logic [DW-1:0]            fwd_data;
    logic                     read_issued;
    rd_state_e                rd_state;
    logic [AW-1:0]            pend_addr;
    logic                     drain_ok;

    assign wr_ready = !full;
    assign push     = wr_valid && wr_ready;
    assign drain_ok = (rd_state == RD_IDLE) || (rd_state == RD_RESP);

    wbuf_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .push_addr(wr_addr),
        .push_data(wr_data), .pop(pop), .head_idx(head_idx),
        .ent_valid(ent_valid), .ent_addr(ent_addr), .ent_data(ent_data),
        .count(buf_count), .full(full), .not_empty(not_empty)
    );

    wbuf_match #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_match (
        .look_addr(rd_addr), .head_idx(head_idx), .ent_valid(ent_valid),
        .ent_addr(ent_addr), .ent_data(ent_data), .hit(fwd_hit),
        .hit_data(fwd_data)
    );

    wbuf_rdctl #(.AW(AW), .DW(DW)) u_rdctl (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .hit(fwd_hit), .hit_data(fwd_data), .read_issued(read_issued),
        .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
        .rd_ready(rd_ready), .rd_resp_valid(rd_resp_valid),
        .rd_resp_data(rd_resp_data), .state(rd_state), .pend_addr(pend_addr)
    );

    wbuf_arb #(.AW(AW), .DW(DW)) u_arb (
        .clk(clk), .rst_n(rst_n), .rd_pend(rd_state == RD_PEND),
        .drain_ok(drain_ok), .have_entry(not_empty),
        .head_addr(ent_addr[head_idx]), .head_data(ent_data[head_idx]),
        .rd_addr(pend_addr), .mem_req_ready(mem_req_ready),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
        .pop(pop), .read_issued(read_issued)
    );
endmodule

// File: rtl/wtbuf_bypass_checks.sv
// Module: wtbuf_bypass_checks
// Property checker bound into wtbuf_bypass; observes ports and a few
// internal nets that separate sub-blocks drive.
// Assumes: synchronous active-low reset on rst_n.
module wtbuf_bypass_checks #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_valid,
    input logic                wr_ready,
    input logic                rd_valid,
    input logic                rd_ready,
    input logic                rd_resp_valid,
    input logic [DW-1:0]       rd_resp_data,
    input logic                mem_req_valid,
    input logic                mem_req_ready,
    input logic                mem_req_write,
    input logic [AW-1:0]       mem_req_addr,
    input logic [DW-1:0]       mem_req_data,
    input logic                mem_resp_valid,
    input logic [DW-1:0]       mem_resp_data,
    input logic [CW-1:0]       buf_count,
    input wbuf_pkg::rd_state_e rd_state,
    input logic                fwd_hit,
    input logic [DW-1:0]       fwd_data
);
    import wbuf_pkg::*;

    // R2: an accepted store with no drain grows the occupancy by one.
    assert_store_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && !(mem_req_valid && mem_req_write && mem_req_ready))
        |=> int'(buf_count) == int'($past(buf_count)) + 1);

    // R3: occupancy never exceeds the queue depth.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(buf_count) <= DEPTH);

    // R3: a full queue refuses stores.
    assert_full_stalls_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(buf_count) == DEPTH) |-> !wr_ready);

    // R5: a presented store stays unchanged until accepted.
    assert_drain_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write && !mem_req_ready)
        |=> mem_req_valid && mem_req_write && $stable(mem_req_addr)
            && $stable(mem_req_data));

    // R7: a matching read is answered next cycle from the queue.
    assert_fwd_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && fwd_hit)
        |=> rd_resp_valid && rd_resp_data == $past(fwd_data));

    // R7: a matching read never produces a memory read.
    assert_fwd_no_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && fwd_hit)
        |=> !(mem_req_valid && !mem_req_write));

    // R9: memory port quiet and reads refused while a read is outstanding.
    assert_quiet_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state == RD_WAIT) |-> !mem_req_valid && !rd_ready);

    // R10: memory read data returns one cycle later.
    assert_mem_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state == RD_WAIT && mem_resp_valid)
        |=> rd_resp_valid && rd_resp_data == $past(mem_resp_data));
endmodule

bind wtbuf_bypass wtbuf_bypass_checks #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_checks (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_resp_valid(rd_resp_valid),
    .rd_resp_data(rd_resp_data), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
    .buf_count(buf_count), .rd_state(rd_state), .fwd_hit(fwd_hit),
    .fwd_data(fwd_data)
);

// File: tb/test_wtbuf_bypass.sv
module test_wtbuf_bypass;
    localparam int AW = 16;
    localparam int DW = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, wr_valid, wr_ready, rd_valid, rd_ready, rd_resp_valid;
    logic [AW-1:0] wr_addr, rd_addr, mem_req_addr;
    logic [DW-1:0] wr_data, rd_resp_data, mem_req_data, mem_resp_data;
    logic          mem_req_valid, mem_req_ready, mem_req_write, mem_resp_valid;

    wtbuf_bypass #(.AW(AW), .DW(DW), .DEPTH(4)) i_wtbuf_bypass (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_resp_valid(rd_resp_valid),
        .rd_resp_data(rd_resp_data), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
        .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data)
    );

    int n_checks = 0;
    int n_err    = 0;

    // memory model state and handshake log
    logic          mem_rdy = 1'b0;
    int            mem_lat = 1;
    int            resp_cnt = 0;
    logic [AW-1:0] resp_addr;
    time           t_resp;
    logic          ev_w [64];
    logic [AW-1:0] ev_a [64];
    logic [DW-1:0] ev_d [64];
    int            ev_n = 0;

    function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
        return {a ^ 16'h3C3C, a};
    endfunction

    // Memory model: acts 2 ns after each falling edge.
    initial begin
        mem_req_ready  = 1'b0;
        mem_resp_valid = 1'b0;
        mem_resp_data  = '0;
        forever begin
            @(negedge clk);
            #2;
            mem_resp_valid = 1'b0;
            if (resp_cnt > 0) begin
                resp_cnt--;
                if (resp_cnt == 0) begin
                    mem_resp_valid = 1'b1;
                    mem_resp_data  = memf(resp_addr);
                    t_resp         = $time;
                end
            end
            mem_req_ready = mem_rdy;
            if (mem_req_valid && mem_req_ready && ev_n < 64) begin
                ev_w[ev_n] = mem_req_write;
                ev_a[ev_n] = mem_req_addr;
                ev_d[ev_n] = mem_req_data;
                ev_n++;
                if (!mem_req_write) begin
                    resp_cnt  = mem_lat;
                    resp_addr = mem_req_addr;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int g = 0;
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        while (!wr_ready && g < 500) begin @(negedge clk); g++; end
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d,
                           output int cyc, output time ts);
        int g = 0;
        rd_valid = 1'b1; rd_addr = a;
        while (!rd_ready && g < 500) begin @(negedge clk); g++; end
        @(negedge clk);
        rd_valid = 1'b0;
        cyc = 1;
        while (!rd_resp_valid && cyc < 500) begin @(negedge clk); cyc++; end
        d  = rd_resp_data;
        ts = $time;
        @(negedge clk);
    endtask

    task automatic wait_ev(input int n);
        int g = 0;
        while (ev_n < n && g < 500) begin @(negedge clk); g++; end
        @(negedge clk);
    endtask

    task automatic chk_ev(input int i, input logic w, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input string req);
        chk(ev_w[i] == w && ev_a[i] == a && (!w || ev_d[i] == d), req,
            $sformatf("memory event %0d kind/addr/data", i),
            {ev_w[i], 15'd0, ev_a[i], ev_d[i]}, {w, 15'd0, a, (w ? d : ev_d[i])});
    endtask

    task automatic t_reset();
        chk(wr_ready == 1'b1, "R1", "wr_ready after reset", 64'(wr_ready), 64'd1);
        chk(rd_ready == 1'b1, "R1", "rd_ready after reset", 64'(rd_ready), 64'd1);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", 64'(mem_req_valid), 64'd0);
        chk(rd_resp_valid == 1'b0, "R1", "rd_resp_valid after reset", 64'(rd_resp_valid), 64'd0);
    endtask

    // Fill, stall, hold and drain in order: R2 R3 R4 R5.
    task automatic t_burst();
        int base = ev_n;
        mem_rdy = 1'b0;
        for (int i = 0; i < 4; i++) push(AW'(10 + i), DW'(100 + i));
        chk(ev_n == base, "R2", "stores absorbed with memory stalled", 64'(ev_n - base), 64'd0);
        chk(wr_ready == 1'b0, "R3", "wr_ready when full", 64'(wr_ready), 64'd0);
        for (int i = 0; i < 3; i++) begin
            chk(mem_req_valid && mem_req_write && mem_req_addr == 16'd10 && mem_req_data == 32'd100,
                "R5", "held store request", 64'(mem_req_addr), 64'd10);
            @(negedge clk);
        end
        fork
            push(16'd14, 32'd104);
            begin
                repeat (2) @(negedge clk);
                chk(wr_ready == 1'b0 && ev_n == base, "R3", "stall while full",
                    64'(wr_ready), 64'd0);
                mem_rdy = 1'b1;
            end
        join
        wait_ev(base + 5);
        for (int i = 0; i < 5; i++) chk_ev(base + i, 1'b1, AW'(10 + i), DW'(100 + i), "R4");
        chk(wr_ready == 1'b1, "R3", "wr_ready after drain", 64'(wr_ready), 64'd1);
    endtask

    // Youngest match forwarded without memory read: R7.
    task automatic t_forward();
        int base = ev_n;
        logic [DW-1:0] d; int cyc; time ts;
        mem_rdy = 1'b0;
        push(16'd40, 32'hA1); push(16'd41, 32'hB2); push(16'd40, 32'hC3);
        do_read(16'd40, d, cyc, ts);
        chk(d == 32'hC3, "R7", "youngest match data", 64'(d), 64'hC3);
        chk(cyc == 1, "R7", "forward latency", 64'(cyc), 64'd1);
        do_read(16'd41, d, cyc, ts);
        chk(d == 32'hB2 && cyc == 1, "R7", "single match data", 64'(d), 64'hB2);
        chk(ev_n == base, "R7", "no memory access on match", 64'(ev_n - base), 64'd0);
        mem_rdy = 1'b1;
        wait_ev(base + 3);
        chk_ev(base, 1'b1, 16'd40, 32'hA1, "R4");
        chk_ev(base + 1, 1'b1, 16'd41, 32'hB2, "R4");
        chk_ev(base + 2, 1'b1, 16'd40, 32'hC3, "R4");
    endtask

    // Bypass past queued store, presented store first, quiet wait: R6 R8 R9 R10.
    task automatic t_bypass();
        int base = ev_n;
        logic [DW-1:0] d; int cyc; time ts;
        mem_rdy = 1'b0; mem_lat = 4;
        push(16'd20, 32'h20); push(16'd21, 32'h21);
        fork
            do_read(16'd30, d, cyc, ts);
            begin
                repeat (2) @(negedge clk);
                chk(mem_req_valid && mem_req_write && mem_req_addr == 16'd20, "R8",
                    "presented store kept over pending read", 64'(mem_req_addr), 64'd20);
                mem_rdy = 1'b1;
                repeat (2) @(negedge clk);
                chk(mem_req_valid == 1'b0 && rd_ready == 1'b0, "R9",
                    "memory quiet during outstanding read", 64'({mem_req_valid, rd_ready}), 64'd0);
            end
        join
        chk(d == memf(16'd30), "R6", "bypass read data", 64'(d), 64'(memf(16'd30)));
        chk(ts - t_resp == 8, "R10", "response one cycle after memory data",
            64'(ts - t_resp), 64'd8);
        wait_ev(base + 3);
        chk_ev(base, 1'b1, 16'd20, 32'h20, "R8");
        chk_ev(base + 1, 1'b0, 16'd30, '0, "R6");
        chk_ev(base + 2, 1'b1, 16'd21, 32'h21, "R6");
        mem_lat = 1;
    endtask

    // Store into full queue while a read is pending: R11.
    task automatic t_full_read();
        int base = ev_n;
        logic [DW-1:0] d; int cyc; time ts;
        mem_rdy = 1'b0;
        for (int i = 0; i < 4; i++) push(AW'(50 + i), DW'(500 + i));
        chk(wr_ready == 1'b0, "R3", "full before combined test", 64'(wr_ready), 64'd0);
        fork
            push(16'd54, 32'd504);
            do_read(16'd60, d, cyc, ts);
            begin repeat (4) @(negedge clk); mem_rdy = 1'b1; end
        join
        wait_ev(base + 6);
        chk(d == memf(16'd60), "R11", "read data with full queue", 64'(d), 64'(memf(16'd60)));
        chk_ev(base, 1'b1, 16'd50, 32'd500, "R11");
        chk_ev(base + 1, 1'b0, 16'd60, '0, "R11");
        for (int i = 1; i < 5; i++) chk_ev(base + 1 + i, 1'b1, AW'(50 + i), DW'(500 + i), "R11");
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_valid = 1'b0; rd_valid = 1'b0;
        wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_burst();
        t_forward();
        t_bypass();
        t_full_read();
        summary();
        $finish;
    end
endmodule